// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the combinational arithmetic and logic stage of a 16-bit processor datapath. Each evaluation takes two operands, an operation code, a byte/word select and the current contents of the flag register. It returns the operation result, a result-write strobe and the next value of the six arithmetic status flags. Flags that the selected operation does not touch are passed through unchanged from the flag input, so the caller can write the flag output straight back into its flag register.

A condition evaluator works alongside the datapath. From the current flags and a 4-bit condition selector it reports whether a conditional branch is taken. It covers signed, unsigned and single-flag tests.

One adder is shared by every add- and subtract-type operation. The operand width is a parameter, and the narrow (byte) mode uses the low half of the same adder. A parameter chooses between a behavioural adder and an explicit bit-level ripple chain.

Top module: `int_alu`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, INC=4, DEC=5, NEG=6, CMP=7, AND=8, OR=9, XOR=10, NOT=11. ADD gives A+B, ADC gives A+B+CF, SUB gives A-B, and SBB gives A-B-CF, where CF is the carry bit of the flag input.
- R2: INC gives A+1, DEC gives A-1, and NEG gives 0-A.
- R3: CMP computes A-B and sets flags exactly as SUB does, but drives `res_wr` low. `res_wr` is high for codes 0 to 6 and 8 to 11.
- R4: AND, OR and XOR produce the bitwise result of A and B, and NOT produces the complement of A. AND, OR and XOR clear CF, AF and OF.
- R5: NOT and the reserved codes 12 to 15 leave all flags unchanged. The reserved codes output A and drive `res_wr` low.
- R6: INC and DEC update OF, SF, ZF, AF and PF but keep CF at its input value.
- R7: CF is the carry out of the operand's top bit for add-type operations, and the borrow out of it for subtract-type operations (SUB, SBB, DEC, NEG, CMP).
- R8: AF is the carry (add) or borrow (subtract) from bit 3 into bit 4.
- R9: OF is set when the signed result of an add- or subtract-type operation does not fit in the selected width.
- R10: PF is 1 when the low byte of the result holds an even number of 1 bits. ZF is 1 when the result at the selected width is zero. SF copies the result's top bit at the selected width.
- R11: `word`=0 selects byte operation. The result's upper byte is then driven to 0, and CF, OF and SF come from bit 7. `word`=1 selects word operation, with these flags taken from bit 15.
- R12: `taken` is computed from `flags_in` by `cond`. Codes 0 to 15 select OF, !OF, CF, !CF, ZF, !ZF, CF|ZF, !(CF|ZF), SF, !SF, PF, !PF, SF^OF, !(SF^OF), (SF^OF)|ZF and !((SF^OF)|ZF). Bit 0 of `cond` inverts the test of the even code.
- R13: Flag vectors are ordered CF=bit 0, PF=bit 1, AF=bit 2, ZF=bit 3, SF=bit 4, OF=bit 5. Every flag bit that an operation does not update is copied from `flags_in` to `flags_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 16 | First operand (the only operand of INC, DEC, NEG, NOT) |
| opnd_b | input | 16 | Second operand |
| op | input | 4 | Operation code |
| word | input | 1 | 1 = word operation, 0 = byte operation |
| flags_in | input | 6 | Current flag register contents |
| cond | input | 4 | Branch condition selector |
| result | output | 16 | Operation result |
| res_wr | output | 1 | Result should be written back |
| flags_out | output | 6 | Next flag register value |
| taken | output | 1 | Selected condition holds on `flags_in` |

## Verification
The bench targets the boundaries where the carry chain and the flags separate. These include 0x7FFF+1 and 0x80-1 for signed overflow, 0xFF+1 in byte mode with upper operand bits set, and 0-1 for borrow. A design that inverted the carry on subtracts, or took a flag from the wrong bit position, would report wrong CF, OF or SF values at exactly these points. NEG of zero and of the most negative value exposes a borrow or overflow computed from the wrong operand. INC and DEC with each input carry value show whether CF leaks through. NOT and the reserved codes, run with a non-zero flag input, show whether flags are overwritten. A full sweep of the sixteen condition codes over several flag patterns catches a swapped pair or a wrong signed combination, and a long pseudo-random run compares every output against an arithmetic model.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_ADC   = 4'd1,
      OP_SUB   = 4'd2,
      OP_SBB   = 4'd3,
      OP_INC   = 4'd4,
      OP_DEC   = 4'd5,
      OP_NEG   = 4'd6,
      OP_CMP   = 4'd7,
      OP_AND   = 4'd8,
      OP_OR    = 4'd9,
      OP_XOR   = 4'd10,
      OP_NOT   = 4'd11,
      OP_RSV12 = 4'd12,
      OP_RSV13 = 4'd13,
      OP_RSV14 = 4'd14,
      OP_RSV15 = 4'd15
   } alu_op_e;

   // bit positions inside a flag vector
   localparam int FL_C = 0;
   localparam int FL_P = 1;
   localparam int FL_A = 2;
   localparam int FL_Z = 3;
   localparam int FL_S = 4;
   localparam int FL_O = 5;
   localparam int FL_N = 6;

   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zro;
      logic aux;
      logic par;
      logic cry;
   } flag_t;

   // operand steering for the shared adder
   typedef struct packed {
      logic x_zero;    // first adder input forced to zero
      logic y_one;     // second adder input is the constant one
      logic y_from_a;  // second adder input taken from operand A
      logic subtract;  // invert second input and carry sense
      logic use_cf;    // fold the incoming carry flag in
   } arith_ctl_t;

   function automatic arith_ctl_t arith_ctl(alu_op_e op);
      arith_ctl_t c;
      c = '0;
      unique case (op)
         OP_ADC:         c.use_cf = 1'b1;
         OP_SUB, OP_CMP: c.subtract = 1'b1;
         OP_SBB:         begin c.subtract = 1'b1; c.use_cf = 1'b1; end
         OP_INC:         c.y_one = 1'b1;
         OP_DEC:         begin c.y_one = 1'b1; c.subtract = 1'b1; end
         OP_NEG:         begin c.x_zero = 1'b1; c.y_from_a = 1'b1; c.subtract = 1'b1; end
         default:        c = '0;
      endcase
      return c;
   endfunction

   function automatic logic is_arith(alu_op_e op);
      return (op <= OP_CMP);
   endfunction

   function automatic logic is_bitwise(alu_op_e op);
      return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOT);
   endfunction

   function automatic logic [FL_N-1:0] upd_mask(alu_op_e op);
      logic [FL_N-1:0] m;
      unique case (op)
         OP_INC, OP_DEC:                 m = 6'b111110;
         OP_NOT, OP_RSV12, OP_RSV13,
         OP_RSV14, OP_RSV15:             m = 6'b000000;
         default:                        m = 6'b111111;
      endcase
      return m;
   endfunction

   function automatic logic writes_result(alu_op_e op);
      return (op != OP_CMP) && (op < OP_RSV12);
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter bit RIPPLE   = 1'b0
) (
   input  logic [DATA_W-1:0]              a,
   input  logic [DATA_W-1:0]              b,
   input  logic                           cf_in,
   input  int_alu_pkg::arith_ctl_t        ctl,
   output logic [DATA_W-1:0]              sum,
   output logic                           c_nib,   // carry into bit 4
   output logic                           c_nmsb,  // carry into narrow top bit
   output logic                           c_nout,  // carry out of narrow width
   output logic                           c_wmsb,  // carry into word top bit
   output logic                           c_wout   // carry out of word width
);

   localparam int NIB = 4;

   logic [DATA_W-1:0] x;
   logic [DATA_W-1:0] y_raw;
   logic [DATA_W-1:0] y;
   logic              c0;

   always_comb begin
      x     = ctl.x_zero ? '0 : a;
      y_raw = ctl.y_one ? DATA_W'(1) : (ctl.y_from_a ? a : b);
      y     = ctl.subtract ? ~y_raw : y_raw;
      c0    = (ctl.use_cf ? cf_in : 1'b0) ^ ctl.subtract;
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [DATA_W:0] cv;
         assign cv[0] = c0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]  = x[i] ^ y[i] ^ cv[i];
            assign cv[i+1] = (x[i] & y[i]) | (cv[i] & (x[i] ^ y[i]));
         end
         assign c_nib  = cv[NIB];
         assign c_nmsb = cv[NARROW_W-1];
         assign c_nout = cv[NARROW_W];
         assign c_wmsb = cv[DATA_W-1];
         assign c_wout = cv[DATA_W];
      end else begin : g_behav
         logic [DATA_W:0] tot;
         assign tot    = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, c0};
         assign sum    = tot[DATA_W-1:0];
         assign c_nib  = tot[NIB] ^ x[NIB] ^ y[NIB];
         assign c_nmsb = tot[NARROW_W-1] ^ x[NARROW_W-1] ^ y[NARROW_W-1];
         assign c_nout = tot[NARROW_W] ^ x[NARROW_W] ^ y[NARROW_W];
         assign c_wmsb = tot[DATA_W-1] ^ x[DATA_W-1] ^ y[DATA_W-1];
         assign c_wout = tot[DATA_W];
      end
   endgenerate

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0]     a,
   input  logic [DATA_W-1:0]     b,
   input  int_alu_pkg::alu_op_e  op,
   output logic [DATA_W-1:0]     y
);
   import int_alu_pkg::*;

   always_comb begin
      unique case (op)
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_NOT:  y = ~a;
         default: y = a;
      endcase
   end

endmodule

// File: rtl/alu_cond.sv
module alu_cond (
   input  logic       cf,
   input  logic       pf,
   input  logic       zf,
   input  logic       sf,
   input  logic       of,
   input  logic [3:0] cond,
   output logic       taken
);

   logic base;
   logic lt;

   always_comb begin
      lt = sf ^ of;
      unique case (cond[3:1])
         3'd0: base = of;
         3'd1: base = cf;
         3'd2: base = zf;
         3'd3: base = cf | zf;
         3'd4: base = sf;
         3'd5: base = pf;
         3'd6: base = lt;
         default: base = lt | zf;
      endcase
      taken = base ^ cond[0];
   end

endmodule

// File: rtl/int_alu.sv
module int_alu #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter bit RIPPLE   = 1'b0
) (
   input  logic [15:0] opnd_a,
   input  logic [15:0] opnd_b,
   input  logic [3:0]  op,
   input  logic        word,
   input  logic [5:0]  flags_in,
   input  logic [3:0]  cond,
   output logic [15:0] result,
   output logic        res_wr,
   output logic [5:0]  flags_out,
   output logic        taken
);
   import int_alu_pkg::*;

   localparam int PAR_W = 8;
   localparam int UP_W  = DATA_W - NARROW_W;

   generate
      if (DATA_W != 16) begin : g_bad_port_w
         $error("int_alu: port widths are fixed at 16 bits");
      end
      if (NARROW_W * 2 != DATA_W) begin : g_bad_ratio
         $error("int_alu: narrow width must be half the data width");
      end
      if (NARROW_W < PAR_W) begin : g_bad_narrow
         $error("int_alu: narrow width must cover the parity byte");
      end
   endgenerate

   alu_op_e         opc;
   arith_ctl_t      actl;
   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] bw_y;
   logic            c_nib, c_nmsb, c_nout, c_wmsb, c_wout;
   logic [DATA_W-1:0] raw;
   logic [DATA_W-1:0] res;
   logic            cout_sel, cmsb_sel, arith;
   flag_t           nf;
   logic [FL_N-1:0] mask;

   assign opc  = alu_op_e'(op);
   assign actl = arith_ctl(opc);

   alu_addsub #(
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W),
      .RIPPLE   (RIPPLE)
   ) u_addsub (
      .a      (opnd_a),
      .b      (opnd_b),
      .cf_in  (flags_in[FL_C]),
      .ctl    (actl),
      .sum    (sum),
      .c_nib  (c_nib),
      .c_nmsb (c_nmsb),
      .c_nout (c_nout),
      .c_wmsb (c_wmsb),
      .c_wout (c_wout)
   );

   alu_bitwise #(
      .DATA_W (DATA_W)
   ) u_bitwise (
      .a  (opnd_a),
      .b  (opnd_b),
      .op (opc),
      .y  (bw_y)
   );

   always_comb begin
      arith    = is_arith(opc);
      raw      = arith ? sum : bw_y;
      res      = word ? raw : {{UP_W{1'b0}}, raw[NARROW_W-1:0]};
      cout_sel = word ? c_wout : c_nout;
      cmsb_sel = word ? c_wmsb : c_nmsb;

      nf.cry = arith & (cout_sel ^ actl.subtract);
      nf.aux = arith & (c_nib ^ actl.subtract);
      nf.ovf = arith & (cmsb_sel ^ cout_sel);
      nf.sgn = word ? res[DATA_W-1] : res[NARROW_W-1];
      nf.zro = ~|res;
      nf.par = ~^res[PAR_W-1:0];

      mask      = upd_mask(opc);
      flags_out = (nf & mask) | (flags_in & ~mask);
      result    = res;
      res_wr    = writes_result(opc);
   end

   alu_cond u_cond (
      .cf    (flags_in[FL_C]),
      .pf    (flags_in[FL_P]),
      .zf    (flags_in[FL_Z]),
      .sf    (flags_in[FL_S]),
      .of    (flags_in[FL_O]),
      .cond  (cond),
      .taken (taken)
   );

endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input logic [15:0] opnd_a,
   input logic [3:0]  op,
   input logic        word,
   input logic [5:0]  flags_in,
   input logic [3:0]  cond,
   input logic [15:0] result,
   input logic        res_wr,
   input logic [5:0]  flags_out,
   input logic        taken
);
   import int_alu_pkg::*;

   always_comb begin
      // R3: compare never writes its result
      a_r3_cmp_no_write: assert (!(op == OP_CMP) || !res_wr)
         else $error("CMP asserted result write");
      // R11: byte mode clears the upper byte
      a_r11_upper_zero: assert (word || (result[DATA_W-1:NARROW_W] == '0))
         else $error("upper byte not zero in byte mode");
      // R5: NOT and reserved codes keep every flag
      a_r5_flags_kept: assert (!((op == OP_NOT) || (op >= OP_RSV12)) || (flags_out == flags_in))
         else $error("flags changed by a no-flag operation");
      // R6: increment and decrement keep the carry
      a_r6_incdec_keep_cf: assert (!((op == OP_INC) || (op == OP_DEC)) || (flags_out[FL_C] == flags_in[FL_C]))
         else $error("carry altered by INC/DEC");
      // R4: logic operations clear carry, aux and overflow
      a_r4_logic_clear: assert (!((op == OP_AND) || (op == OP_OR) || (op == OP_XOR))
                                || (flags_out[FL_C] == 1'b0 && flags_out[FL_A] == 1'b0 && flags_out[FL_O] == 1'b0))
         else $error("logic op left C/A/O set");
      // R10: zero flag matches the result wherever it is updated
      a_r10_zero_flag: assert (!(op <= OP_XOR) || (flags_out[FL_Z] == (result == '0)))
         else $error("zero flag disagrees with result");
      // R12: the equal test follows the zero flag
      a_r12_equal_cond: assert (!(cond == 4'd4) || (taken == flags_in[FL_Z]))
         else $error("equal condition disagrees with ZF");
      // R4: NOT complements operand A in word mode
      a_r4_not_result: assert (!((op == OP_NOT) && word) || (result == ~opnd_a))
         else $error("NOT result wrong");
   end

endmodule

bind int_alu alu_chk #(
   .DATA_W   (DATA_W),
   .NARROW_W (NARROW_W)
) u_alu_chk (
   .opnd_a    (opnd_a),
   .op        (op),
   .word      (word),
   .flags_in  (flags_in),
   .cond      (cond),
   .result    (result),
   .res_wr    (res_wr),
   .flags_out (flags_out),
   .taken     (taken)
);

// File: tb/tb_int_alu.sv
module tb_int_alu;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] opnd_a = '0;
   logic [15:0] opnd_b = '0;
   logic [3:0]  op = '0;
   logic        word = 1'b1;
   logic [5:0]  flags_in = '0;
   logic [3:0]  cond = '0;
   logic [15:0] result;
   logic        res_wr;
   logic [5:0]  flags_out;
   logic        taken;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int unsigned st = 32'h1234_5678;

   always #10 clk = ~clk;

   int_alu dut (
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .op        (op),
      .word      (word),
      .flags_in  (flags_in),
      .cond      (cond),
      .result    (result),
      .res_wr    (res_wr),
      .flags_out (flags_out),
      .taken     (taken)
   );

   typedef struct {
      logic [15:0] res;
      logic        wr;
      logic [5:0]  fl;
      logic        tk;
      string       tag;
   } exp_t;

   exp_t q[$];

   function automatic logic cond_model(logic [5:0] f, logic [3:0] cc);
      logic b;
      case (cc[3:1])
         3'd0: b = f[5];
         3'd1: b = f[0];
         3'd2: b = f[3];
         3'd3: b = f[0] | f[3];
         3'd4: b = f[4];
         3'd5: b = f[1];
         3'd6: b = f[4] ^ f[5];
         default: b = (f[4] ^ f[5]) | f[3];
      endcase
      return b ^ cc[0];
   endfunction

   function automatic exp_t model(logic [3:0] o, logic [15:0] av, logic [15:0] bv,
                                  logic w, logic [5:0] fi, logic [3:0] cc, string tag);
      exp_t e;
      int n, mask, half, x, y, cin, r, rn, sx, sy, sr, pc;
      bit sub, arith;
      logic [5:0] nf, um;
      n = w ? 16 : 8;
      mask = (1 << n) - 1;
      half = 1 << (n - 1);
      x = int'(av) & mask;
      y = int'(bv) & mask;
      cin = 0; sub = 0; arith = 1; nf = '0;
      case (o)
         4'd0: ;
         4'd1: cin = int'(fi[0]);
         4'd2: sub = 1;
         4'd3: begin sub = 1; cin = int'(fi[0]); end
         4'd4: y = 1;
         4'd5: begin y = 1; sub = 1; end
         4'd6: begin y = x; x = 0; sub = 1; end
         4'd7: sub = 1;
         default: arith = 0;
      endcase
      if (arith) begin
         if (sub) begin
            r = x - y - cin;
            rn = (x & 15) - (y & 15) - cin;
            nf[0] = (r < 0);
            nf[2] = (rn < 0);
         end else begin
            r = x + y + cin;
            rn = (x & 15) + (y & 15) + cin;
            nf[0] = (r > mask);
            nf[2] = (rn > 15);
         end
         sx = (x >= half) ? x - 2 * half : x;
         sy = (y >= half) ? y - 2 * half : y;
         sr = sub ? sx - sy - cin : sx + sy + cin;
         nf[5] = (sr > half - 1) || (sr < -half);
      end else begin
         case (o)
            4'd8:  r = x & y;
            4'd9:  r = x | y;
            4'd10: r = x ^ y;
            4'd11: r = (~x) & mask;
            default: r = x;
         endcase
      end
      r = r & mask;
      nf[3] = (r == 0);
      nf[4] = (((r >> (n - 1)) & 1) == 1);
      pc = 0;
      for (int i = 0; i < 8; i++) pc += (r >> i) & 1;
      nf[1] = ((pc % 2) == 0);
      if (o == 4'd4 || o == 4'd5) um = 6'b111110;
      else if (o <= 4'd10)        um = 6'b111111;
      else                        um = 6'b000000;
      e.fl  = (nf & um) | (fi & ~um);
      e.res = r[15:0];
      e.wr  = !(o == 4'd7 || o >= 4'd12);
      e.tk  = cond_model(fi, cc);
      e.tag = tag;
      return e;
   endfunction

   task automatic drive(logic [3:0] o, logic [15:0] av, logic [15:0] bv, logic w,
                        logic [5:0] fi, logic [3:0] cc, string tag);
      @(posedge clk);
      #2;
      op = o; opnd_a = av; opnd_b = bv; word = w; flags_in = fi; cond = cc;
      q.push_back(model(o, av, bv, w, fi, cc, tag));
   endtask

   // monitor: compares one queued item per cycle, away from the rising edge
   always @(negedge clk) begin
      if (!rst && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (result !== e.res || res_wr !== e.wr || flags_out !== e.fl || taken !== e.tk) begin
            failures++;
            $display("FAIL %s: op=%0d a=%h b=%h w=%0b fin=%b cond=%0d | got res=%h wr=%0b fl=%b tk=%0b | exp res=%h wr=%0b fl=%b tk=%0b",
                     e.tag, op, opnd_a, opnd_b, word, flags_in, cond,
                     result, res_wr, flags_out, taken, e.res, e.wr, e.fl, e.tk);
         end
      end
   end

   function automatic int unsigned next_rand(int unsigned s);
      int unsigned v;
      v = s;
      v ^= v << 13;
      v ^= v >> 17;
      v ^= v << 5;
      return v;
   endfunction

   initial begin
      #(20 * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset-state style check: all-zero inputs
      drive(4'd0, 16'h0000, 16'h0000, 1'b1, 6'b000000, 4'd0, "R1 idle zero add");
      // R1 add family
      drive(4'd0, 16'h1234, 16'h4321, 1'b1, 6'b000000, 4'd0, "R1 add");
      drive(4'd1, 16'hFFFF, 16'h0000, 1'b1, 6'b000001, 4'd0, "R1 adc carry in");
      drive(4'd3, 16'h0080, 16'h0000, 1'b0, 6'b000001, 4'd0, "R9 sbb byte overflow");
      drive(4'd2, 16'h0000, 16'h0001, 1'b1, 6'b000000, 4'd0, "R7 sub borrow");
      // R9 signed overflow on word add
      drive(4'd0, 16'h7FFF, 16'h0001, 1'b1, 6'b000000, 4'd0, "R9 add overflow");
      // R11 byte wrap with upper operand bits set
      drive(4'd0, 16'h12FF, 16'hAB01, 1'b0, 6'b000000, 4'd0, "R11 byte wrap");
      // R8 aux carry only
      drive(4'd0, 16'h000F, 16'h0001, 1'b1, 6'b000000, 4'd0, "R8 aux carry");
      drive(4'd2, 16'h0010, 16'h0001, 1'b1, 6'b000000, 4'd0, "R8 aux borrow");
      // R6 INC/DEC keep CF for both values
      drive(4'd4, 16'hFFFF, 16'h0000, 1'b1, 6'b000000, 4'd0, "R6 inc wrap cf0");
      drive(4'd4, 16'h7FFF, 16'h0000, 1'b1, 6'b000001, 4'd0, "R6 inc cf1");
      drive(4'd5, 16'h0000, 16'h0000, 1'b0, 6'b000001, 4'd0, "R6 dec byte cf1");
      drive(4'd5, 16'h8000, 16'h0000, 1'b1, 6'b000000, 4'd0, "R2 dec overflow");
      // R2 NEG corners
      drive(4'd6, 16'h8000, 16'h1111, 1'b1, 6'b000000, 4'd0, "R2 neg min");
      drive(4'd6, 16'h0000, 16'h1111, 1'b1, 6'b000001, 4'd0, "R2 neg zero");
      drive(4'd6, 16'h0001, 16'h0000, 1'b0, 6'b000000, 4'd0, "R2 neg byte one");
      // R3 compare
      drive(4'd7, 16'h0005, 16'h0007, 1'b1, 6'b000000, 4'd0, "R3 cmp less");
      drive(4'd7, 16'h0042, 16'h0042, 1'b0, 6'b111111, 4'd0, "R3 cmp equal");
      // R4 logic ops with all flags set on input
      drive(4'd8, 16'hF0F0, 16'hFF00, 1'b1, 6'b111111, 4'd0, "R4 and clears");
      drive(4'd9, 16'h0001, 16'h0002, 1'b0, 6'b111111, 4'd0, "R4 or byte");
      drive(4'd10, 16'h00FF, 16'h00FF, 1'b1, 6'b100101, 4'd0, "R4 xor zero");
      drive(4'd11, 16'h5A5A, 16'h0000, 1'b1, 6'b101010, 4'd0, "R5 not keeps flags");
      drive(4'd11, 16'h5A5A, 16'h0000, 1'b0, 6'b010101, 4'd0, "R13 not byte passthrough");
      // R5 reserved codes
      for (int k = 12; k < 16; k++)
         drive(4'(k), 16'hBEEF, 16'h1234, 1'b1, 6'b110011, 4'd0, "R5 reserved");
      // R10 parity on low byte only
      drive(4'd9, 16'h0300, 16'h0001, 1'b1, 6'b000000, 4'd0, "R10 parity odd");
      drive(4'd9, 16'h0100, 16'h0003, 1'b1, 6'b000000, 4'd0, "R10 parity even");
      // R12 condition sweep
      for (int p = 0; p < 4; p++) begin
         logic [5:0] fp;
         case (p)
            0: fp = 6'b000000;
            1: fp = 6'b101001;
            2: fp = 6'b010110;
            default: fp = 6'b011000;
         endcase
         for (int c = 0; c < 16; c++)
            drive(4'd11, 16'h0000, 16'h0000, 1'b1, fp, 4'(c), "R12 condition");
      end
      // R1/R7/R9/R13 pseudo-random mix
      for (int i = 0; i < 400; i++) begin
         logic [15:0] ra, rb;
         logic [3:0] ro, rc;
         logic [5:0] rf;
         logic rw;
         st = next_rand(st); ra = st[15:0]; rb = st[31:16];
         st = next_rand(st); ro = st[3:0]; rc = st[7:4]; rf = st[13:8]; rw = st[16];
         drive(ro, ra, rb, rw, rf, rc, "R13 random mix");
      end
      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule